// File: doc/BRIEF.md
# Register-Accessed Descriptor Queue Bank

This block keeps a bank of hardware FIFOs, each holding references to packet descriptors. Software sees every queue as one 32-bit data word. A write to that word appends an entry to the queue. A read of that word removes the oldest entry and returns it. Each entry combines two fields. The upper 28 bits hold the pointer to a descriptor on a 16-byte boundary. The lower 4 bits hold a prefetch size hint, counted in 16-byte units. The block stores the whole word and returns it unchanged.

There are two access ports. The write port carries an address, a strobe and data. The read port carries an address and a strobe, and returns read data one clock later. Each access acts on the queue state in a single clock edge, so no partial state can ever be seen. A zero pointer field has its own meaning: reading an empty queue returns zero, and writing a word with a zero pointer field empties the queue. A push to a full queue is discarded and sets a sticky overflow flag for that queue. Software reads these flags from a status word placed just after the last queue, and clears them by writing ones there. Every queue also drives an empty flag and an entry count as outputs.

Top module: `dqm_top`

## Requirements
- R1: A write to word address q (0 to NQ-1) whose bits 31:4 are not zero appends the whole 32-bit word to queue q. At the clock edge that accepts the write, the count of queue q rises by one and its empty flag falls.
- R2: A read of word address q captures the oldest entry of queue q into `rd_data` and removes that entry at the same clock edge. Entries come out in the order they were written.
- R3: The size hint in bits 3:0 and the pointer in bits 31:4 are returned exactly as they were written.
- R4: A read of an empty queue returns 32'h0000_0000, and the count stays at 0.
- R5: A write to a queue address with bits 31:4 equal to zero pushes nothing, whatever the value of bits 3:0. It discards every entry of that queue: the count becomes 0, the empty flag becomes 1, and the next read returns 0.
- R6: A write to a queue that holds DEPTH entries, with no read of that queue in the same cycle, is dropped. The stored entries and the count do not change, and the overflow flag of that queue (`q_ovf` bit q) is set.
- R7: The overflow flags stay set until they are cleared. A write to word address NQ clears flag q wherever data bit q is 1, and leaves flags whose bit is 0 unchanged. A read of address NQ returns the flags in bits NQ-1:0 and zeros above them, and removes nothing from any queue.
- R8: When a write and a read reach the same queue in one cycle, the pop is done first and the push second. On an empty queue the read returns 0 and the count ends at 1. On a full queue the read returns the head, the new entry is kept, the count stays at DEPTH and no overflow is flagged.
- R9: An access to one queue leaves the contents, count, empty flag and overflow flag of every other queue unchanged.
- R10: `q_count` (CW bits per queue, where queue q is in bits q*CW +: CW) and `q_empty` show the new state right after the clock edge that completes each push, pop or flush.
- R11: `rd_data` keeps its value in cycles with no read. A read of an address above NQ returns 0. A write to an address above NQ changes no queue and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Word address of the read |
| rd_data | output | 32 | Read data, valid in the cycle after the strobe |
| q_empty | output | NQ | Empty flag of each queue |
| q_count | output | NQ*CW | Entry count of each queue |
| q_ovf | output | NQ | Sticky overflow flag of each queue |

## Verification
A read or write pointer that moves wrongly inside a queue does not show up right away. It appears when a later pop returns the wrong word or the wrong order, possibly many accesses after the fault. For this reason the tests fill every queue they use and then drain it completely. A count that has gone wrong shows up at once on `q_count` and `q_empty`, in the cycle after the access. A wrong flush or overflow decision also shows at once: the count changes when it should not, or the flag does not change when it should. Pops that happen together with pushes, on both an empty and a full queue, cover the ordering where the count is most likely to slip by one.

// File: rtl/dqm_pkg.sv
// Package: shared constants for the descriptor queue bank.
// Assumes 32-bit data words in which bits 31:4 hold the pointer field.
package dqm_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned PTR_LSB = 4;

    // True when the pointer field of a word is zero (flush code / empty read)
    function automatic logic ptr_is_zero(input logic [WORD_W-1:0] w);
        return (w[WORD_W-1:PTR_LSB] == '0);
    endfunction
endpackage

// File: rtl/dqm_decode.sv
// Module: dqm_decode
// Turns the write and read port accesses into one-hot per-queue strobes:
// push, flush, pop and overflow clear. It also flags reads of the status word.
// Assumes 2 <= NQ < 32. Queues sit at word addresses 0..NQ-1 and the status word at NQ.
module dqm_decode #(
    parameter int unsigned NQ = 8,
    parameter int unsigned AW = 4
) (
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [dqm_pkg::WORD_W-1:0] wr_data,
    input  logic                      rd_en,
    input  logic [AW-1:0]             rd_addr,
    output logic [NQ-1:0]             push,
    output logic [NQ-1:0]             flush,
    output logic [NQ-1:0]             pop,
    output logic [NQ-1:0]             ovf_clr,
    output logic                      stat_rd
);
    localparam logic [AW-1:0] STAT_ADDR = AW'(NQ);

    logic wr_zero;

    // Pointer field check used to tell a flush from a push
    always_comb wr_zero = dqm_pkg::ptr_is_zero(wr_data);

    // One strobe per queue from the address compares
    for (genvar q = 0; q < NQ; q++) begin : g_dec
        localparam logic [AW-1:0] QADDR = AW'(q);
        always_comb begin
            push[q]    = wr_en && (wr_addr == QADDR) && !wr_zero;
            flush[q]   = wr_en && (wr_addr == QADDR) &&  wr_zero;
            pop[q]     = rd_en && (rd_addr == QADDR);
            ovf_clr[q] = wr_en && (wr_addr == STAT_ADDR) && wr_data[q];
        end
    end

    // Read of the overflow status word
    always_comb stat_rd = rd_en && (rd_addr == STAT_ADDR);
endmodule

// File: rtl/dqm_queue.sv
// Module: dqm_queue
// A single descriptor FIFO with a pop-then-push order within one cycle,
// flush-to-empty, and a sticky overflow flag set when a push is dropped.
// The head output shows zero while the queue is empty.
// Assumes push and flush never arrive together (the decoder makes them exclusive).
module dqm_queue #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       flush,
    input  logic                       pop,
    input  logic                       ovf_clr,
    input  logic [dqm_pkg::WORD_W-1:0] wdata,
    output logic [dqm_pkg::WORD_W-1:0] head,
    output logic [CW-1:0]              count,
    output logic                       empty,
    output logic                       ovf
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [dqm_pkg::WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt, cnt_mid;
    logic          do_pop, do_push, drop;

    // Wrapping pointer step that also works when DEPTH is not a power of two
    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Pop is applied first, then the push is judged against the count left after it
    always_comb begin
        do_pop  = pop && (cnt != '0);
        cnt_mid = cnt - CW'(do_pop);
        do_push = push && !flush && (cnt_mid < FULL);
        drop    = push && !flush && (cnt_mid == FULL);
    end

    // Entry storage; only accepted pushes write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointers and count; a flush returns the queue to the reset state
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_pop)  rd_ptr <= step(rd_ptr);
            if (do_push) wr_ptr <= step(wr_ptr);
            cnt <= cnt_mid + CW'(do_push);
        end
    end

    // Sticky overflow flag; a new drop wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (drop)    ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    // Outputs: head word (zero when empty), count and empty flag
    always_comb begin
        head  = (cnt == '0) ? '0 : mem[rd_ptr];
        count = cnt;
        empty = (cnt == '0);
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0) && empty);                                   // R5
    AST_FULL_PUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && count == FULL) |=> (count == FULL) && ovf); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);                                           // R7
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);                                                       // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop && !flush) |=> $stable(count));                        // R9
    AST_SIMUL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush && count != '0) |=> $stable(count) && !$rose(ovf)); // R8
endmodule

// File: rtl/dqm_top.sv
// Module: dqm_top
// A bank of NQ descriptor queues accessed through a write port and a read port.
// A write to a queue word pushes (or flushes when the pointer field is zero).
// A read of a queue word pops, and the data is registered for the next cycle.
// Word NQ is the overflow status register, cleared by writing ones.
// Assumes 2 <= NQ < 32.
module dqm_top #(
    parameter int unsigned NQ    = 8,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = $clog2(NQ + 1),
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [31:0]          wr_data,
    input  logic                 rd_en,
    input  logic [AW-1:0]        rd_addr,
    output logic [31:0]          rd_data,
    output logic [NQ-1:0]        q_empty,
    output logic [NQ*CW-1:0]     q_count,
    output logic [NQ-1:0]        q_ovf
);
    localparam int unsigned QW = $clog2(NQ);
    localparam logic [AW-1:0] STAT_ADDR = AW'(NQ);

    logic [NQ-1:0] push, flush, pop, ovf_clr;
    logic          stat_rd;
    logic [31:0]   heads [NQ];
    logic          sel_q, sel_empty;

    dqm_decode #(.NQ(NQ), .AW(AW)) dec_i (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .push    (push),
        .flush   (flush),
        .pop     (pop),
        .ovf_clr (ovf_clr),
        .stat_rd (stat_rd)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        dqm_queue #(.DEPTH(DEPTH), .CW(CW)) queue_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (push[q]),
            .flush   (flush[q]),
            .pop     (pop[q]),
            .ovf_clr (ovf_clr[q]),
            .wdata   (wr_data),
            .head    (heads[q]),
            .count   (q_count[q*CW +: CW]),
            .empty   (q_empty[q]),
            .ovf     (q_ovf[q])
        );
    end

    // Read address hits a queue word; empty state of that queue for the checker
    always_comb begin
        sel_q     = rd_addr < STAT_ADDR;
        sel_empty = sel_q && q_empty[rd_addr[QW-1:0]];
    end

    // Registered read data: queue head, status word or zero; holds when idle
    always_ff @(posedge clk) begin
        if (!rst_n)             rd_data <= '0;
        else if (stat_rd)       rd_data <= {{(32-NQ){1'b0}}, q_ovf};
        else if (rd_en && sel_q) rd_data <= heads[rd_addr[QW-1:0]];
        else if (rd_en)         rd_data <= '0;
    end

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_empty) |=> (rd_data == '0));                       // R4
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));                                    // R11
    AST_ONE_POP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));                                                  // R9
endmodule

// File: tb/dqm_top_tb.sv
module dqm_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NQ = 8;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(NQ + 1);
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [NQ-1:0] q_empty, q_ovf;
    logic [NQ*CW-1:0] q_count;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dqm_top #(.NQ(NQ), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .q_empty(q_empty), .q_count(q_count), .q_ovf(q_ovf)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cnt_of(input int q);
        return 32'(q_count[q*CW +: CW]);
    endfunction

    // One bus cycle: drive after the falling edge, sample 1 time unit after the rising edge
    task automatic acc(input logic we, input int wa, input logic [31:0] wd, input logic re, input int ra);
        @(negedge clk);
        wr_en = we; wr_addr = AW'(wa); wr_data = wd;
        rd_en = re; rd_addr = AW'(ra);
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic push(input int q, input logic [31:0] d); acc(1'b1, q, d, 1'b0, 0); endtask
    task automatic pop(input int q); acc(1'b0, 0, 0, 1'b1, q); endtask

    function automatic logic [31:0] val(input int base, input int i);
        return 32'(base) + 32'(i << 4) + 32'(i & 15);
    endfunction

    task automatic t_reset();
        chk("R10", "reset empty", 32'(q_empty), 32'hFF);
        chk("R10", "reset counts", 32'(q_count == '0), 32'd1);
        chk("R7", "reset ovf", 32'(q_ovf), 32'h0);
        chk("R11", "reset rd_data", rd_data, 32'h0);
    endtask

    task automatic t_fifo_order();
        push(2, 32'hABCD_1235);
        chk("R1", "q2 count after 1 push", cnt_of(2), 1);
        chk("R10", "q2 empty after push", 32'(q_empty[2]), 0);
        push(2, 32'h0000_0010);
        push(2, 32'hFFFF_FFFF);
        chk("R1", "q2 count after 3 pushes", cnt_of(2), 3);
        pop(2);
        chk("R3", "q2 first pop", rd_data, 32'hABCD_1235);
        chk("R10", "q2 count after pop", cnt_of(2), 2);
        pop(2);
        chk("R2", "q2 second pop", rd_data, 32'h0000_0010);
        pop(2);
        chk("R3", "q2 third pop", rd_data, 32'hFFFF_FFFF);
        chk("R10", "q2 empty after drain", 32'(q_empty[2]), 1);
        acc(1'b0, 0, 0, 1'b0, 0);
        chk("R11", "rd_data holds when idle", rd_data, 32'hFFFF_FFFF);
    endtask

    task automatic t_empty_read();
        pop(5);
        chk("R4", "empty q5 read", rd_data, 32'h0);
        chk("R4", "empty q5 count", cnt_of(5), 0);
    endtask

    task automatic t_flush();
        push(1, 32'h0000_0123);
        push(1, 32'h0000_0457);
        acc(1'b1, 1, 32'h0000_000F, 1'b0, 0);
        chk("R5", "q1 count after flush", cnt_of(1), 0);
        chk("R5", "q1 empty after flush", 32'(q_empty[1]), 1);
        pop(1);
        chk("R5", "q1 read after flush", rd_data, 32'h0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH; i++) push(3, val(32'h0003_0000, i));
        chk("R1", "q3 full count", cnt_of(3), DEPTH);
        chk("R6", "q3 no ovf yet", 32'(q_ovf[3]), 0);
        push(3, 32'hDEAD_BEE0);
        chk("R6", "q3 count after dropped push", cnt_of(3), DEPTH);
        chk("R6", "q3 ovf set", 32'(q_ovf[3]), 1);
        chk("R9", "other ovf clear", 32'(q_ovf & ~8'h08), 0);
        pop(NQ);
        chk("R7", "status read", rd_data, 32'h0000_0008);
        chk("R7", "status read pops nothing", cnt_of(3), DEPTH);
        push(NQ, 32'h0000_00F7);
        chk("R7", "ovf kept when bit 0", 32'(q_ovf[3]), 1);
        push(NQ, 32'h0000_0008);
        chk("R7", "ovf cleared", 32'(q_ovf[3]), 0);
        for (int i = 0; i < DEPTH; i++) begin
            pop(3);
            chk("R6", $sformatf("q3 pop %0d", i), rd_data, val(32'h0003_0000, i));
        end
        chk("R10", "q3 empty after drain", 32'(q_empty[3]), 1);
    endtask

    task automatic t_simul();
        acc(1'b1, 4, 32'h0004_00E1, 1'b1, 4);
        chk("R8", "simul on empty reads 0", rd_data, 32'h0);
        chk("R8", "simul on empty count", cnt_of(4), 1);
        for (int i = 1; i < DEPTH; i++) push(4, val(32'h0040_0000, i));
        chk("R8", "q4 full", cnt_of(4), DEPTH);
        acc(1'b1, 4, 32'h0000_0AB2, 1'b1, 4);
        chk("R8", "simul on full reads head", rd_data, 32'h0004_00E1);
        chk("R8", "simul on full count", cnt_of(4), DEPTH);
        chk("R8", "simul on full no ovf", 32'(q_ovf[4]), 0);
        for (int i = 1; i < DEPTH; i++) pop(4);
        chk("R8", "q4 next to last", rd_data, val(32'h0040_0000, DEPTH - 1));
        pop(4);
        chk("R8", "q4 pushed word kept", rd_data, 32'h0000_0AB2);
    endtask

    task automatic t_indep();
        push(6, 32'h0006_6660);
        pop(7);
        chk("R9", "q7 read stays empty", rd_data, 32'h0);
        chk("R9", "q6 count kept", cnt_of(6), 1);
        acc(1'b1, 7, 32'h0000_0005, 1'b0, 0);
        chk("R9", "flush q7 keeps q6", cnt_of(6), 1);
        pop(6);
        chk("R9", "q6 word", rd_data, 32'h0006_6660);
    endtask

    task automatic t_out_of_range();
        push(0, 32'h0000_1110);
        push(12, 32'hFFFF_FFFF);
        chk("R11", "write above NQ keeps counts", 32'(q_count), 32'(CW'(1)));
        chk("R11", "write above NQ keeps ovf", 32'(q_ovf), 0);
        pop(15);
        chk("R11", "read above NQ", rd_data, 32'h0);
        chk("R11", "read above NQ no pop", cnt_of(0), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_fifo_order();
        t_empty_read();
        t_flush();
        t_overflow();
        t_simul();
        t_indep();
        t_out_of_range();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule